// File: doc/BRIEF.md
# CPU Bank-Byte Capture and Physical Memory Mapper

This block joins a 16-bit-address CPU bus that multiplexes an extra address byte onto its data lines to one large external RAM with a 25-bit physical address. In the first half of every bus cycle the data lines carry the upper eight bits of a 24-bit address. The block captures that byte and holds it for the second half. It then forms the full CPU address and translates it into a physical RAM address, a chip enable and a write strobe, all registered.

There are two ways to run it. In native mode the captured byte and the 16-bit address form a flat 16MB space that maps straight onto the lower half of the RAM. In legacy mode the captured byte is ignored, so the CPU sees only one 64KB space. Two windows in that space are bank-switched into zones of the upper half of the RAM: an 8KB high-RAM window and a 16KB ROM window. Each is steered by an 8-bit bank register that the CPU writes and reads at two low addresses. ROM banks below 32 land in a soft-ROM zone that accepts writes only while a load-enable input is high. Higher ROM banks land in a writable expansion zone.

Top module: `bank_mapper`

## Requirements
- R1: After reset, ram_ce, ram_we and reg_rd_valid are 0, and both bank registers read back 0.
- R2: The byte on cpu_data is captured at each rising edge where bus_phase is 0, and it is held while bus_phase is 1. In native mode (legacy_mode=0), a data-phase cycle produces ram_addr = {1'b0, bank byte, cpu_addr} with ram_ce=1 after that cycle's rising edge.
- R3: In legacy mode the bank byte has no effect. Any address outside the register and window ranges maps to {1'b0, 8'h00, cpu_addr}.
- R4: In legacy mode, addresses 0xA000–0xBFFF map to 0x1000000 + {ram bank register, cpu_addr[12:0]}. Bank 255 at 0xBFFF gives 0x11FFFFF.
- R5: In legacy mode, addresses 0xC000–0xFFFF map to 0x1200000 + {rom bank register, cpu_addr[13:0]}. For ROM banks 0–31 (the soft-ROM zone 0x1200000–0x127FFFF), ram_we is raised on a write only while rom_load_en is 1.
- R6: ROM banks 32–255 fall in the expansion zone 0x1280000–0x15FFFFF. That zone is always writable, and bank 255 at 0xFFFF gives 0x15FFFFF.
- R7: In legacy mode a write (cpu_rw=0) to 0x0000 loads the RAM bank register and a write to 0x0001 loads the ROM bank register. A read of either address sets reg_rd_valid=1 with reg_rd_data equal to the register value. Register accesses never raise ram_ce.
- R8: ram_we is 1 only together with ram_ce, and only for a cpu_rw=0 data-phase cycle. A cycle with bus_phase=0 yields ram_ce=0, ram_we=0 and reg_rd_valid=0.
- R9: In native mode, addresses 0x0000/0x0001 and the window ranges are ordinary flat RAM. They leave the bank registers unchanged and always map into the lower physical half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all outputs are registered on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_mode | input | 1 | 1 selects 64KB legacy mapping with bank windows, 0 selects flat 24-bit mapping |
| bus_phase | input | 1 | 0 = address phase (cpu_data carries bank byte), 1 = data phase |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data lines: bank byte in address phase, write data in data phase |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| rom_load_en | input | 1 | Permits writes into the soft-ROM zone |
| ram_addr | output | 25 | Registered physical RAM address |
| ram_ce | output | 1 | Registered RAM chip enable |
| ram_we | output | 1 | Registered RAM write strobe |
| reg_rd_valid | output | 1 | Registered flag that reg_rd_data holds a bank-register read |
| reg_rd_data | output | 8 | Registered bank-register read value |

## Verification
Every result comes from one register stage. The bank byte captured at the address-phase edge is used by the data-phase cycle that follows. The address, enable, strobe and register read-back of that data-phase cycle appear right after its own rising edge, and a bank-register write takes effect for the next data phase. The bench drives inputs and samples outputs only on falling edges. It checks each data phase at the falling edge after its rising edge, and it checks the idle outputs at the falling edge after each address-phase edge. The expected bank registers are updated only after the comparison, so a register write is checked on later cycles, never in the cycle that issues it.

// File: rtl/map_pkg.sv
package map_pkg;

    typedef enum logic [2:0] {
        TGT_FLAT,
        TGT_HIRAM,
        TGT_ROMWIN,
        TGT_REG_RAMBANK,
        TGT_REG_ROMBANK
    } tgt_e;

    typedef struct packed {
        logic [24:0] addr;
        logic        ce;
        logic        we;
        logic        rd_valid;
        logic [7:0]  rd_data;
    } port_state_t;

    typedef struct packed {
        logic [7:0] ram_bank;
        logic [7:0] rom_bank;
    } bank_regs_t;

endpackage

// File: rtl/bank_latch.sv
module bank_latch #(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [BANK_W-1:0] din,
    output logic [BANK_W-1:0] bank
);
    logic [BANK_W-1:0] bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (capture) bank_d = din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign bank = bank_q;

    // Byte must stay put through the data phase
    assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture && $past(rst_n)) |=> $stable(bank_q));

endmodule

// File: rtl/bank_regs.sv
module bank_regs #(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ram,
    input  logic              wr_rom,
    input  logic [BANK_W-1:0] din,
    output logic [BANK_W-1:0] ram_bank,
    output logic [BANK_W-1:0] rom_bank
);
    import map_pkg::*;

    bank_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_ram) regs_d.ram_bank = din;
        if (wr_rom) regs_d.rom_bank = din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign ram_bank = regs_q.ram_bank;
    assign rom_bank = regs_q.rom_bank;

    assert_ram_bank_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ram |=> (ram_bank == $past(din)));
    assert_rom_bank_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rom |=> (rom_bank == $past(din)));
    assert_one_reg_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ram && wr_rom));

endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
    import map_pkg::*;
#(
    parameter int              PA_W          = 25,
    parameter int              CPU_AW        = 16,
    parameter int              BANK_W        = 8,
    parameter logic [PA_W-1:0] HIRAM_BASE    = 25'h1000000,
    parameter logic [PA_W-1:0] ROM_BASE      = 25'h1200000,
    parameter int              SOFTROM_BANKS = 32,
    parameter logic [CPU_AW-1:0] HIWIN_START = 16'hA000,
    parameter int              HIWIN_BITS    = 13,
    parameter logic [CPU_AW-1:0] ROMWIN_START = 16'hC000,
    parameter int              ROMWIN_BITS   = 14,
    parameter logic [CPU_AW-1:0] REG_RAMBANK  = 16'h0000,
    parameter logic [CPU_AW-1:0] REG_ROMBANK  = 16'h0001
) (
    input  logic              legacy,
    input  logic [BANK_W-1:0] bank_byte,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [BANK_W-1:0] ram_bank,
    input  logic [BANK_W-1:0] rom_bank,
    input  logic              load_en,
    output tgt_e              tgt,
    output logic [PA_W-1:0]   phys,
    output logic              wr_ok
);
    localparam int HI_TAG_W  = CPU_AW - HIWIN_BITS;
    localparam int ROM_TAG_W = CPU_AW - ROMWIN_BITS;
    localparam int FLAT_PAD  = PA_W - BANK_W - CPU_AW;
    localparam int HI_PAD    = PA_W - BANK_W - HIWIN_BITS;
    localparam int ROM_PAD   = PA_W - BANK_W - ROMWIN_BITS;
    localparam logic [HI_TAG_W-1:0]  HI_TAG  = HIWIN_START[CPU_AW-1:HIWIN_BITS];
    localparam logic [ROM_TAG_W-1:0] ROM_TAG = ROMWIN_START[CPU_AW-1:ROMWIN_BITS];
    localparam logic [BANK_W-1:0]    SR_LIM  = BANK_W'(SOFTROM_BANKS);

    logic              in_hi, in_rom;
    logic [BANK_W-1:0] flat_bank;
    logic [PA_W-1:0]   flat_pa, hi_pa, rom_pa;

    assign in_hi     = (cpu_addr[CPU_AW-1:HIWIN_BITS]  == HI_TAG);
    assign in_rom    = (cpu_addr[CPU_AW-1:ROMWIN_BITS] == ROM_TAG);
    assign flat_bank = legacy ? '0 : bank_byte;
    assign flat_pa   = {{FLAT_PAD{1'b0}}, flat_bank, cpu_addr};
    assign hi_pa     = HIRAM_BASE + {{HI_PAD{1'b0}}, ram_bank, cpu_addr[HIWIN_BITS-1:0]};
    assign rom_pa    = ROM_BASE + {{ROM_PAD{1'b0}}, rom_bank, cpu_addr[ROMWIN_BITS-1:0]};

    always_comb begin
        tgt   = TGT_FLAT;
        phys  = flat_pa;
        wr_ok = 1'b1;
        if (legacy) begin
            if (cpu_addr == REG_RAMBANK) begin
                tgt = TGT_REG_RAMBANK;
            end else if (cpu_addr == REG_ROMBANK) begin
                tgt = TGT_REG_ROMBANK;
            end else if (in_hi) begin
                tgt  = TGT_HIRAM;
                phys = hi_pa;
            end else if (in_rom) begin
                tgt   = TGT_ROMWIN;
                phys  = rom_pa;
                wr_ok = (rom_bank >= SR_LIM) || load_en;
            end
        end
    end

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import map_pkg::*;
#(
    parameter int              PA_W          = 25,
    parameter int              CPU_AW        = 16,
    parameter int              BANK_W        = 8,
    parameter logic [PA_W-1:0] HIRAM_BASE    = 25'h1000000,
    parameter logic [PA_W-1:0] ROM_BASE      = 25'h1200000,
    parameter int              SOFTROM_BANKS = 32,
    parameter int              ROMWIN_BITS   = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              legacy_mode,
    input  logic              bus_phase,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [BANK_W-1:0] cpu_data,
    input  logic              cpu_rw,
    input  logic              rom_load_en,
    output logic [PA_W-1:0]   ram_addr,
    output logic              ram_ce,
    output logic              ram_we,
    output logic              reg_rd_valid,
    output logic [BANK_W-1:0] reg_rd_data
);
    localparam logic [PA_W-1:0] SR_END = ROM_BASE + PA_W'(SOFTROM_BANKS) * (PA_W'(1) << ROMWIN_BITS);

    logic [BANK_W-1:0] bank_byte, ram_bank, rom_bank;
    logic [PA_W-1:0]   phys;
    logic              wr_ok, is_reg, wr_ram_reg, wr_rom_reg;
    tgt_e              tgt;
    port_state_t       st_d, st_q;

    bank_latch #(.BANK_W(BANK_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (!bus_phase),
        .din     (cpu_data),
        .bank    (bank_byte)
    );

    addr_xlate #(
        .PA_W          (PA_W),
        .CPU_AW        (CPU_AW),
        .BANK_W        (BANK_W),
        .HIRAM_BASE    (HIRAM_BASE),
        .ROM_BASE      (ROM_BASE),
        .SOFTROM_BANKS (SOFTROM_BANKS),
        .ROMWIN_BITS   (ROMWIN_BITS)
    ) u_xlate (
        .legacy    (legacy_mode),
        .bank_byte (bank_byte),
        .cpu_addr  (cpu_addr),
        .ram_bank  (ram_bank),
        .rom_bank  (rom_bank),
        .load_en   (rom_load_en),
        .tgt       (tgt),
        .phys      (phys),
        .wr_ok     (wr_ok)
    );

    assign is_reg     = (tgt == TGT_REG_RAMBANK) || (tgt == TGT_REG_ROMBANK);
    assign wr_ram_reg = bus_phase && !cpu_rw && (tgt == TGT_REG_RAMBANK);
    assign wr_rom_reg = bus_phase && !cpu_rw && (tgt == TGT_REG_ROMBANK);

    bank_regs #(.BANK_W(BANK_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ram   (wr_ram_reg),
        .wr_rom   (wr_rom_reg),
        .din      (cpu_data),
        .ram_bank (ram_bank),
        .rom_bank (rom_bank)
    );

    always_comb begin
        st_d          = st_q;
        st_d.addr     = phys;
        st_d.ce       = bus_phase && !is_reg;
        st_d.we       = bus_phase && !is_reg && !cpu_rw && wr_ok;
        st_d.rd_valid = bus_phase && is_reg && cpu_rw;
        if (bus_phase && cpu_rw && tgt == TGT_REG_RAMBANK) st_d.rd_data = ram_bank;
        if (bus_phase && cpu_rw && tgt == TGT_REG_ROMBANK) st_d.rd_data = rom_bank;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ram_addr     = st_q.addr;
    assign ram_ce       = st_q.ce;
    assign ram_we       = st_q.we;
    assign reg_rd_valid = st_q.rd_valid;
    assign reg_rd_data  = st_q.rd_data;

    assert_we_with_ce_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ram_ce);
    assert_idle_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_phase |=> (!ram_ce && !ram_we && !reg_rd_valid));
    assert_we_from_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_phase && cpu_rw) |=> !ram_we);
    assert_softrom_protect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_phase && !cpu_rw && !rom_load_en) |=>
            !(ram_we && ram_addr >= ROM_BASE && ram_addr < SR_END));
    assert_reg_no_ce_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_valid |-> !ram_ce);
    assert_native_low_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_phase && !legacy_mode) |=> (ram_ce && !ram_addr[PA_W-1]));

endmodule

// File: tb/sim_bank_mapper.sv
`timescale 1ns/1ps
module sim_bank_mapper;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        legacy_mode, bus_phase, cpu_rw, rom_load_en;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_data;
    logic [24:0] ram_addr;
    logic        ram_ce, ram_we, reg_rd_valid;
    logic [7:0]  reg_rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] m_ram_bank = 8'h00;
    logic [7:0] m_rom_bank = 8'h00;

    always #2.5 clk = ~clk;

    bank_mapper u0 (
        .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode), .bus_phase(bus_phase),
        .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_rw(cpu_rw), .rom_load_en(rom_load_en),
        .ram_addr(ram_addr), .ram_ce(ram_ce), .ram_we(ram_we),
        .reg_rd_valid(reg_rd_valid), .reg_rd_data(reg_rd_data)
    );

    typedef struct packed {
        logic [24:0] addr;
        logic        ce;
        logic        we;
        logic        rdv;
        logic [7:0]  rdd;
    } exp_t;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic exp_t model(input logic leg, input logic [7:0] bnk,
                                   input logic [15:0] a, input logic rw, input logic ld);
        exp_t e;
        e = '0;
        if (leg && (a == 16'h0000 || a == 16'h0001)) begin
            e.rdv = rw;
            e.rdd = (a == 16'h0000) ? m_ram_bank : m_rom_bank;
        end else if (leg && a >= 16'hA000 && a <= 16'hBFFF) begin
            e.ce = 1'b1; e.we = !rw;
            e.addr = 25'h1000000 + {4'b0, m_ram_bank, a[12:0]};
        end else if (leg && a >= 16'hC000) begin
            e.ce = 1'b1; e.we = !rw && (m_rom_bank >= 8'd32 || ld);
            e.addr = 25'h1200000 + {3'b0, m_rom_bank, a[13:0]};
        end else begin
            e.ce = 1'b1; e.we = !rw;
            e.addr = {1'b0, (leg ? 8'h00 : bnk), a};
        end
        return e;
    endfunction

    // One full bus cycle: address phase then data phase; checks both.
    task automatic bus_cycle(input string req, input logic leg, input logic [7:0] bnk,
                             input logic [15:0] a, input logic [7:0] d,
                             input logic rw, input logic ld);
        exp_t e;
        bus_phase = 1'b0; legacy_mode = leg; cpu_data = bnk;
        cpu_addr = a; cpu_rw = 1'b1; rom_load_en = ld;
        @(posedge clk); @(negedge clk);
        chk("R8 idle ce", 32'(ram_ce), 0);
        chk("R8 idle we", 32'(ram_we), 0);
        chk("R8 idle rdv", 32'(reg_rd_valid), 0);
        bus_phase = 1'b1; cpu_data = d; cpu_rw = rw;
        e = model(leg, bnk, a, rw, ld);
        @(posedge clk); @(negedge clk);
        chk({req, " ce"}, 32'(ram_ce), 32'(e.ce));
        chk({req, " we (R8)"}, 32'(ram_we), 32'(e.we));
        chk({req, " rdv"}, 32'(reg_rd_valid), 32'(e.rdv));
        if (e.ce)  chk({req, " addr"}, 32'(ram_addr), 32'(e.addr));
        if (e.rdv) chk({req, " rdata"}, 32'(reg_rd_data), 32'(e.rdd));
        if (leg && !rw && a == 16'h0000) m_ram_bank = d;
        if (leg && !rw && a == 16'h0001) m_rom_bank = d;
    endtask

    initial begin
        #750000;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; legacy_mode = 1'b0; bus_phase = 1'b1; cpu_addr = 16'h0;
        cpu_data = 8'h0; cpu_rw = 1'b1; rom_load_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        chk("R1 ce", 32'(ram_ce), 0);
        chk("R1 we", 32'(ram_we), 0);
        chk("R1 rdv", 32'(reg_rd_valid), 0);
        bus_cycle("R1 rambank read", 1, 8'h55, 16'h0000, 8'h00, 1, 0);
        bus_cycle("R1 rombank read", 1, 8'h55, 16'h0001, 8'h00, 1, 0);
        // R2: native flat mapping
        bus_cycle("R2 native top", 0, 8'hFF, 16'hFFFF, 8'h12, 0, 0);
        bus_cycle("R2 native mid", 0, 8'h3C, 16'h1234, 8'h00, 1, 0);
        // R3: bank byte ignored in legacy mode
        bus_cycle("R3 legacy flat", 1, 8'hFF, 16'h1234, 8'h00, 1, 0);
        // R7: bank register writes and readback
        bus_cycle("R7 wr rambank", 1, 8'h00, 16'h0000, 8'hFF, 0, 0);
        bus_cycle("R7 rd rambank", 1, 8'h00, 16'h0000, 8'h00, 1, 0);
        // R4: high RAM window corners
        bus_cycle("R4 hiram top", 1, 8'h77, 16'hBFFF, 8'h00, 0, 0);
        bus_cycle("R4 hiram base", 1, 8'h77, 16'hA000, 8'h00, 1, 0);
        // R5: soft-ROM protection around the bank 31/32 boundary
        bus_cycle("R7 wr rombank", 1, 8'h00, 16'h0001, 8'd31, 0, 0);
        bus_cycle("R5 softrom wr locked", 1, 8'h00, 16'hFFFF, 8'h00, 0, 0);
        bus_cycle("R5 softrom wr loading", 1, 8'h00, 16'hC000, 8'h00, 0, 1);
        bus_cycle("R7 wr rombank", 1, 8'h00, 16'h0001, 8'd32, 0, 0);
        bus_cycle("R6 expansion base wr", 1, 8'h00, 16'hC000, 8'h00, 0, 0);
        bus_cycle("R7 wr rombank", 1, 8'h00, 16'h0001, 8'd255, 0, 0);
        bus_cycle("R6 expansion top wr", 1, 8'h00, 16'hFFFF, 8'h00, 0, 0);
        // R9: native accesses at register addresses leave registers alone
        bus_cycle("R9 native addr0 wr", 0, 8'h00, 16'h0000, 8'h5A, 0, 0);
        bus_cycle("R9 native addr1 wr", 0, 8'h01, 16'h0001, 8'h5A, 0, 0);
        bus_cycle("R9 native window", 0, 8'h80, 16'hC123, 8'h00, 0, 0);
        bus_cycle("R9 regs kept ram", 1, 8'h00, 16'h0000, 8'h00, 1, 0);
        bus_cycle("R9 regs kept rom", 1, 8'h00, 16'h0001, 8'h00, 1, 0);
        // Constrained random mix
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1500; i++) begin
            logic [15:0] a;
            int sel;
            sel = $urandom_range(0, 9);
            case (sel)
                0:       a = 16'($urandom_range(0, 1));
                1, 2:    a = 16'hA000 + 16'($urandom_range(0, 16'h1FFF));
                3, 4, 5: a = 16'hC000 + 16'($urandom_range(0, 16'h3FFF));
                default: a = 16'($urandom);
            endcase
            bus_cycle((sel == 0) ? "R7 rand reg" : (sel < 3) ? "R4 rand hiram" :
                      (sel < 6) ? "R5 R6 rand rom" : "R2 R3 rand flat",
                      1'($urandom_range(0, 3) != 0), 8'($urandom), a, 8'($urandom),
                      1'($urandom), 1'($urandom));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule